// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Unit

This block keeps the transmit and receive byte queues of a UART-style peripheral. It turns their fill levels into raw interrupt bits and status flags. The serial side pushes received bytes in and drains transmit bytes out. The host side writes and reads a single data port. A loopback control sends host writes straight into the receive queue.

Each direction has a 3-bit level select that picks a threshold. The receive and transmit interrupt bits change only when the fill level crosses that threshold. The rule differs for a rising and a falling level and for each direction. When the queues are switched off, each one shrinks to a single entry and uses fixed thresholds. Switching the queues off also empties them. Serial shifting, baud timing and register decoding belong to other blocks.

Top module: `uart_fifo_irq`

## Requirements
- R1: With queues on, the depth is 32 (DEPTH). Select codes 0, 1, 2, 3 and 4 give thresholds of 4, 8, 16, 24 and 28 entries. Codes 5, 6 and 7 give 16.
- R2: With `fifo_en` low, each queue holds one entry, the transmit threshold is 0 and the receive threshold is 1.
- R3: `irq_rx` sets in the cycle in which an arrival moves `rx_level` from below the receive threshold to at or above it.
- R4: A host read that leaves `rx_level` below the receive threshold clears `irq_rx`.
- R5: `irq_tx` sets in the cycle in which draining moves `tx_level` from above the transmit threshold to at or below it.
- R6: A host write that leaves `tx_level` above the transmit threshold clears `irq_tx`.
- R7: `irq_rt` is high exactly when the receive queue holds at least one byte.
- R8: A host read while the receive queue is empty returns 0 on `host_rdata` and changes no level or interrupt bit.
- R9: With `loop_en` high, a host write enters the receive queue only when `uart_on`, `tx_on` and `rx_on` are all high. The transmit queue is untouched and `rx_push` is ignored.
- R10: A byte that reaches a full receive queue is dropped and sets `irq_oe`. `oe_clr` clears `irq_oe`.
- R11: `flag_busy` is high when the transmit queue is not empty. `flag_tx_empty` and `flag_rx_empty` show an empty queue. `flag_tx_full` and `flag_rx_full` show a level at or above the current depth. `flag_cts`, `flag_dcd` and `flag_dsr` follow `connected`.
- R12: A host write to a full transmit queue drops the oldest byte and keeps the new one. Both queues deliver bytes in arrival order.
- R13: When `fifo_en` goes from high to low, both queues are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| fifo_en | input | 1 | queues on (depth DEPTH) or off (depth 1) |
| loop_en | input | 1 | send host writes to the receive queue |
| uart_on | input | 1 | peripheral enable, used in loopback |
| tx_on | input | 1 | transmit enable, used in loopback |
| rx_on | input | 1 | receive enable, used in loopback |
| connected | input | 1 | link present, drives the modem flags |
| tx_lvl_sel | input | 3 | transmit threshold select |
| rx_lvl_sel | input | 3 | receive threshold select |
| rx_push | input | 1 | serial side delivers a byte |
| rx_byte | input | DW | byte from the serial side |
| tx_pop | input | 1 | serial side takes the oldest transmit byte |
| tx_byte | output | DW | oldest transmit byte |
| host_wr | input | 1 | host data write |
| host_wdata | input | DW | host write data |
| host_rd | input | 1 | host data read, pops the receive queue |
| host_rdata | output | DW | oldest receive byte, 0 when empty |
| oe_clr | input | 1 | clears the overrun bit |
| tx_level | output | LW | transmit fill level |
| rx_level | output | LW | receive fill level |
| irq_rx | output | 1 | receive threshold interrupt |
| irq_tx | output | 1 | transmit threshold interrupt |
| irq_rt | output | 1 | receive data waiting |
| irq_oe | output | 1 | receive overrun |
| flag_busy | output | 1 | transmit queue not empty |
| flag_rx_empty | output | 1 | receive queue empty |
| flag_tx_full | output | 1 | transmit queue full |
| flag_rx_full | output | 1 | receive queue full |
| flag_tx_empty | output | 1 | transmit queue empty |
| flag_cts | output | 1 | clear-to-send status |
| flag_dcd | output | 1 | carrier-detect status |
| flag_dsr | output | 1 | data-set-ready status |

## Verification
The hardest case to reach is a threshold crossing in the falling direction that follows a long fill. Examples are the receive bit clearing at 15 of 16 after 32 arrivals and the transmit bit setting as a full queue drains past 4. The stimulus runs both queues to full through the ports and then empties them one byte at a time. It checks the data order against a scoreboard queue and reads the interrupt bits at each crossing. A second hard case is the switch from queues on to queues off. The stimulus loads both queues, lowers `fifo_en` to flush them, and then repeats the threshold rules at depth one.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          loop_en,
  input  logic          uart_on,
  input  logic          tx_on,
  input  logic          rx_on,
  input  logic          connected,
  input  logic [2:0]    tx_lvl_sel,
  input  logic [2:0]    rx_lvl_sel,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_byte,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          oe_clr,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_rt,
  output logic          irq_oe,
  output logic          flag_busy,
  output logic          flag_rx_empty,
  output logic          flag_tx_full,
  output logic          flag_rx_full,
  output logic          flag_tx_empty,
  output logic          flag_cts,
  output logic          flag_dcd,
  output logic          flag_dsr
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  localparam int PW = $clog2(DEPTH);

  function automatic logic [LW-1:0] level_of(input logic [2:0] s);
    case (s)
      3'd0:    return LW'(DEPTH / 8);
      3'd1:    return LW'(DEPTH / 4);
      3'd3:    return LW'(3 * DEPTH / 4);
      3'd4:    return LW'(7 * DEPTH / 8);
      default: return LW'(DEPTH / 2);
    endcase
  endfunction

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_hd, tx_tl, rx_hd, rx_tl;
  logic [LW-1:0] tx_lvl, rx_lvl, tx_nxt, rx_nxt;
  logic [LW-1:0] cap, tx_trig, rx_trig;
  logic          en_q, flush;
  logic          rx_in, rx_pop, rx_acc, rx_ovf;
  logic          tx_wr, tx_drn, tx_drop;
  logic [DW-1:0] rx_din;

  assign cap     = fifo_en ? LW'(DEPTH) : LW'(1);
  assign tx_trig = fifo_en ? level_of(tx_lvl_sel) : LW'(0);
  assign rx_trig = fifo_en ? level_of(rx_lvl_sel) : LW'(1);
  assign flush   = en_q & ~fifo_en;

  assign rx_in   = loop_en ? (host_wr & uart_on & tx_on & rx_on) : rx_push;
  assign rx_din  = loop_en ? host_wdata : rx_byte;
  assign rx_pop  = host_rd & (rx_lvl != '0);
  assign rx_acc  = rx_in & ((rx_lvl < cap) | rx_pop);
  assign rx_ovf  = rx_in & ~rx_acc;
  assign rx_nxt  = rx_lvl + LW'(rx_acc) - LW'(rx_pop);

  assign tx_wr   = host_wr & ~loop_en;
  assign tx_drn  = tx_pop & (tx_lvl != '0);
  assign tx_drop = tx_wr & ~tx_drn & (tx_lvl >= cap);
  assign tx_nxt  = tx_lvl + LW'(tx_wr) - LW'(tx_drn) - LW'(tx_drop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      tx_hd  <= '0;
      tx_tl  <= '0;
      rx_hd  <= '0;
      rx_tl  <= '0;
      tx_lvl <= '0;
      rx_lvl <= '0;
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
      irq_oe <= 1'b0;
    end else begin
      en_q <= fifo_en;
      if (flush) begin
        tx_hd  <= '0;
        tx_tl  <= '0;
        rx_hd  <= '0;
        rx_tl  <= '0;
        tx_lvl <= '0;
        rx_lvl <= '0;
      end else begin
        if (rx_acc) rx_tl <= rx_tl + 1'b1;
        if (rx_pop) rx_hd <= rx_hd + 1'b1;
        if (tx_wr) tx_tl <= tx_tl + 1'b1;
        if (tx_drn | tx_drop) tx_hd <= tx_hd + 1'b1;
        rx_lvl <= rx_nxt;
        tx_lvl <= tx_nxt;
        if (rx_lvl < rx_trig && rx_nxt >= rx_trig) irq_rx <= 1'b1;
        else if (rx_pop && rx_nxt < rx_trig) irq_rx <= 1'b0;
        if (tx_lvl > tx_trig && tx_nxt <= tx_trig) irq_tx <= 1'b1;
        else if (tx_wr && tx_nxt > tx_trig) irq_tx <= 1'b0;
      end
      if (rx_ovf && !flush) irq_oe <= 1'b1;
      else if (oe_clr) irq_oe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_acc && !flush) rx_mem[rx_tl] <= rx_din;
    if (tx_wr && !flush) tx_mem[tx_tl] <= host_wdata;
  end

  assign tx_byte       = tx_mem[tx_hd];
  assign host_rdata    = (rx_lvl == '0) ? '0 : rx_mem[rx_hd];
  assign tx_level      = tx_lvl;
  assign rx_level      = rx_lvl;
  assign irq_rt        = rx_lvl != '0;
  assign flag_busy     = tx_lvl != '0;
  assign flag_tx_empty = tx_lvl == '0;
  assign flag_rx_empty = rx_lvl == '0;
  assign flag_tx_full  = tx_lvl >= cap;
  assign flag_rx_full  = rx_lvl >= cap;
  assign flag_cts      = connected;
  assign flag_dcd      = connected;
  assign flag_dsr      = connected;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          loop_en,
  input logic [2:0]    tx_lvl_sel,
  input logic [2:0]    rx_lvl_sel,
  input logic          tx_pop,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          irq_rx,
  input logic          irq_tx
);
  function automatic int thr(input logic [2:0] s, input logic on, input int off_val);
    if (!on) return off_val;
    case (s)
      3'd0: return DEPTH / 8;
      3'd1: return DEPTH / 4;
      3'd3: return (DEPTH * 3) / 4;
      3'd4: return (DEPTH * 7) / 8;
      default: return DEPTH / 2;
    endcase
  endfunction

  int rt, tt, cp;
  assign rt = thr(rx_lvl_sel, fifo_en, 1);
  assign tt = thr(tx_lvl_sel, fifo_en, 0);
  assign cp = fifo_en ? DEPTH : 1;

  p_level_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) <= DEPTH) && (int'(tx_level) <= DEPTH));

  p_rx_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) && $stable(rx_lvl_sel) && $stable(fifo_en)
    |-> int'(rx_level) >= rt && int'($past(rx_level)) < rt);

  p_rx_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_rx) && $stable(rx_lvl_sel) && $stable(fifo_en)
    |-> int'(rx_level) < rt);

  p_tx_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) && $stable(tx_lvl_sel) && $stable(fifo_en)
    |-> int'(tx_level) <= tt && int'($past(tx_level)) > tt);

  p_tx_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx) && $stable(tx_lvl_sel) && $stable(fifo_en)
    |-> int'(tx_level) > tt);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && rx_level == '0 |-> host_rdata == '0);

  p_loop_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en && host_wr && !tx_pop && $stable(fifo_en)
    |=> tx_level == $past(tx_level));

  p_full_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !loop_en && !tx_pop && int'(tx_level) == cp && $stable(fifo_en)
    |=> tx_level == $past(tx_level));
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .loop_en(loop_en),
  .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel), .tx_pop(tx_pop),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .tx_level(tx_level), .rx_level(rx_level), .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/uart_fifo_irq_test.sv
module uart_fifo_irq_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int LW     = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, loop_en = 0, uart_on = 0, tx_on = 0, rx_on = 0, connected = 0;
  logic [2:0] tx_lvl_sel = 3'd2, rx_lvl_sel = 3'd2;
  logic rx_push = 0, tx_pop = 0, host_wr = 0, host_rd = 0, oe_clr = 0;
  logic [7:0] rx_byte = 0, host_wdata = 0, tx_byte, host_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic irq_rx, irq_tx, irq_rt, irq_oe;
  logic flag_busy, flag_rx_empty, flag_tx_full, flag_rx_full, flag_tx_empty;
  logic flag_cts, flag_dcd, flag_dsr;

  int total = 0, bad = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always #(PERIOD/2) clk = ~clk;

  uart_fifo_irq uut (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap();
    return fifo_en ? DEPTH : 1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_rx(logic [7:0] b);
    rx_push = 1; rx_byte = b;
    if (!loop_en && rxq.size() < cap()) rxq.push_back(b);
    tick(); rx_push = 0;
  endtask

  task automatic host_write(logic [7:0] b);
    host_wr = 1; host_wdata = b;
    if (loop_en) begin
      if (uart_on && tx_on && rx_on && rxq.size() < cap()) rxq.push_back(b);
    end else begin
      if (txq.size() >= cap()) void'(txq.pop_front());
      txq.push_back(b);
    end
    tick(); host_wr = 0;
  endtask

  // monitor side of the scoreboard: compare what the port shows with the oldest expected byte
  task automatic host_read(string req);
    int exp;
    host_rd = 1;
    exp = (rxq.size() != 0) ? int'(rxq.pop_front()) : 0;
    #1 check(req, int'(host_rdata), exp);
    tick(); host_rd = 0;
  endtask

  task automatic drain(string req);
    tx_pop = 1;
    if (txq.size() != 0) #1 check(req, int'(tx_byte), int'(txq.pop_front()));
    tick(); tx_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // reset state, R11
    check("R11 reset rx_level", int'(rx_level), 0);
    check("R11 reset tx_level", int'(tx_level), 0);
    check("R11 reset empty flags", {flag_rx_empty, flag_tx_empty, flag_busy}, 3'b110);
    check("R7 reset irq_rt", irq_rt, 0);
    check("R11 modem flags low", {flag_cts, flag_dcd, flag_dsr}, 0);
    connected = 1; #1;
    check("R11 modem flags follow connected", {flag_cts, flag_dcd, flag_dsr}, 3'b111);

    // R1/R3: threshold 4 on the receive side
    fifo_en = 1; rx_lvl_sel = 3'd0; tick();
    for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i));
    check("R3 below threshold", irq_rx, 0);
    check("R7 rt with data", irq_rt, 1);
    push_rx(8'h13);
    check("R3 R1 crossing at 4", irq_rx, 1);
    host_read("R12 rx order");
    check("R4 read leaves 3", irq_rx, 0);
    for (int i = 0; i < 3; i++) host_read("R12 rx order");
    check("R7 rt empty", irq_rt, 0);
    // R8: empty read
    host_read("R8 empty read data");
    check("R8 level kept", int'(rx_level), 0);
    check("R8 irq kept", irq_rx, 0);

    // R1: invalid code maps to 16
    rx_lvl_sel = 3'd7; tick();
    for (int i = 0; i < 15; i++) push_rx(8'(i + 40));
    check("R1 code 7 below 16", irq_rx, 0);
    push_rx(8'd55);
    check("R1 code 7 crossing at 16", irq_rx, 1);
    // R10: fill and overrun
    for (int i = 0; i < 16; i++) push_rx(8'(i + 100));
    check("R11 rx full flag", flag_rx_full, 1);
    check("R10 no overrun yet", irq_oe, 0);
    push_rx(8'hEE);
    check("R10 overrun set", irq_oe, 1);
    check("R10 level stays full", int'(rx_level), 32);
    oe_clr = 1; tick(); oe_clr = 0;
    check("R10 overrun cleared", irq_oe, 0);
    for (int i = 0; i < 16; i++) host_read("R12 rx order after overrun");
    check("R4 still 16", irq_rx, 1);
    host_read("R12 rx order after overrun");
    check("R4 read leaves 15", irq_rx, 0);
    while (rxq.size() != 0) host_read("R12 rx order after overrun");

    // R5/R6: transmit threshold 4
    tx_lvl_sel = 3'd0; tick();
    for (int i = 0; i < 5; i++) host_write(8'(i + 200));
    check("R11 busy", {flag_busy, flag_tx_empty}, 2'b10);
    check("R5 no set on writes", irq_tx, 0);
    drain("R12 tx order");
    check("R5 drain to 4", irq_tx, 1);
    host_write(8'd205);
    check("R6 write to 5 clears", irq_tx, 0);
    while (txq.size() != 0) drain("R12 tx order");
    check("R11 tx empty", flag_tx_empty, 1);

    // R12: overwrite oldest when full
    for (int i = 0; i < 33; i++) host_write(8'(i));
    check("R12 tx level full", int'(tx_level), 32);
    check("R11 tx full flag", flag_tx_full, 1);
    while (txq.size() != 0) drain("R12 oldest dropped");
    check("R5 set after drain", irq_tx, 1);

    // R13: flush on disable
    host_write(8'hA1); push_rx(8'hB2);
    fifo_en = 0; tick(); rxq.delete(); txq.delete();
    check("R13 tx flushed", int'(tx_level), 0);
    check("R13 rx flushed", int'(rx_level), 0);

    // R2: depth one
    push_rx(8'h31);
    check("R2 rx trigger 1", irq_rx, 1);
    check("R2 rx full at 1", flag_rx_full, 1);
    push_rx(8'h32);
    check("R2 R10 overrun at depth 1", irq_oe, 1);
    host_read("R2 rx data");
    check("R2 R4 clear at 0", irq_rx, 0);
    host_write(8'h41);
    check("R2 R6 tx above 0 clears", irq_tx, 0);
    check("R2 tx full at 1", flag_tx_full, 1);
    host_write(8'h42);
    check("R2 R12 tx level held", int'(tx_level), 1);
    drain("R2 R12 newest kept");
    check("R2 R5 tx trigger 0", irq_tx, 1);
    oe_clr = 1; tick(); oe_clr = 0;

    // R9: loopback
    fifo_en = 1; loop_en = 1; uart_on = 1; tx_on = 1; rx_on = 1; tick();
    host_write(8'hA5);
    check("R9 loop into rx", int'(rx_level), 1);
    check("R9 tx untouched", int'(tx_level), 0);
    push_rx(8'h77);
    check("R9 serial ignored", int'(rx_level), 1);
    rx_on = 0; tick();
    host_write(8'h5A);
    check("R9 gated by rx_on", int'(rx_level), 1);
    check("R9 tx still untouched", int'(tx_level), 0);
    rx_on = 1; tick();
    host_read("R9 loop data");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule